// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector Unit

This block sits beside an I2C master core and turns the core's one-cycle event pulses into software-visible state on a 16-bit register bus. Each event sets a sticky bit in a status register. Software acknowledges an event by writing a one to its bit. An enable mask selects which events drive the single level interrupt line. The bus-busy input is shown live in the status word. It is never stored and never interrupts.

For software that handles one event per interrupt, a vector register reports the most urgent pending enabled event as a 3-bit code. Reading that register acknowledges the reported event, so the next read gives the next event. Register reads are combinational: read data is valid in the same cycle as the read strobe. Any read-to-clear action takes place at the clock edge that ends that cycle.

Top module: `evt_irq_unit`

## Requirements
- R1: An event pulse on `ev_pulse` bit i sets status bit i on the next clock edge, and the bit stays set. This holds for the sticky positions 0 (arbitration lost), 1 (no-acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 8, 9, 10, 11, 13 and 14. Pulses on bits 5 to 7, 12 and 15 are ignored.
- R2: A write to the status register (address 0) clears every sticky bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: If an event pulse arrives in the same cycle as a clear of that bit, by status write or by vector read, the bit is set after the edge.
- R4: Status bit 12 always equals the `bus_busy` input. Writes and event pulses do not affect it.
- R5: The enable register (address 1) stores only bits 14, 13 and 4 to 0. Its other bits read as 0.
- R6: `irq_o` is high exactly when some status bit and its enable bit are both 1. The bus-busy bit never raises `irq_o`.
- R7: With the enable register at zero, `irq_o` stays low while status bits remain set.
- R8: The vector register (address 2) reads as code k+1 for the lowest set bit k among status bits 4 to 0 that are also enabled. It reads 0 when no such bit is set, so code 1 (arbitration lost) has the highest priority and code 5 (transmit ready) the lowest.
- R9: A vector read clears only the status bit it reports. A vector read that returns 0 changes nothing, and a read of the status or enable register clears nothing.
- R10: Reset clears all status and enable bits.
- R11: A read of address 3 returns 0. Read data is valid combinationally while `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 16 | One-cycle event pulses, bit i targets status bit i |
| bus_busy | input | 1 | Live bus-busy level from the core |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a collision: an event pulse in the very cycle that clears the same bit, through a status write or a vector read. The bench drives the pulse and the strobe on the same falling edge, so both reach the design at one rising edge. It then reads the bit back. The priority walk is also covered. Several vector-capable events are left pending with some of them masked, and the vector is read repeatedly, checking that each read removes exactly the reported event and leaves the others set.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int DW = 16;
  localparam logic [DW-1:0] STICKY_MASK = 16'h6F1F;
  localparam logic [DW-1:0] EN_MASK     = 16'h601F;
  localparam int BB_BIT  = 12;
  localparam int NVEC    = 5;
  localparam int CODE_W  = $clog2(NVEC + 1);

  // Lowest pending source wins; code is index + 1, zero when idle.
  function automatic logic [CODE_W-1:0] vec_code(input logic [NVEC-1:0] pend);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (pend[i]) c = CODE_W'(i + 1);
    return c;
  endfunction

  // Sticky update: set beats clear.
  function automatic logic [DW-1:0] stat_next(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] set,
                                              input logic [DW-1:0] clr);
    return ((cur & ~clr) | set) & STICKY_MASK;
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import i2c_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_set,
  input  logic [DW-1:0] clr,
  output logic [DW-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_next(stat_q, ev_set, clr);
  end

  // R1 / R3: a sticky event is visible after the edge, whatever the clear did
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_set & STICKY_MASK)) |=>
      ((stat_q & $past(ev_set & STICKY_MASK)) == $past(ev_set & STICKY_MASK)));

  // R2: without clear or event the register holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0 && ev_set == '0) |=> $stable(stat_q));

  // R4: live busy position is never stored
  a_r4_bb_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[BB_BIT]);
endmodule

// File: rtl/evt_vec_enc.sv
module evt_vec_enc
  import i2c_evt_pkg::*;
(
  input  logic [NVEC-1:0]   pend,
  input  logic              rd_vec,
  output logic [CODE_W-1:0] code,
  output logic [NVEC-1:0]   clr_vec
);
  always_comb begin
    code    = vec_code(pend);
    clr_vec = '0;
    for (int i = 0; i < NVEC; i++)
      if (rd_vec && code == CODE_W'(i + 1)) clr_vec[i] = 1'b1;
  end

  // R9: one vector read acknowledges at most one event, and only a pending one
  always_comb begin
    a_r9_single_clear: assert ($onehot0(clr_vec) && ((clr_vec & ~pend) == '0));
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import i2c_evt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     ev_pulse,
  input  logic              bus_busy,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(2);

  logic [DW-1:0]     stat_q, en_q, clr_w, clr_all, pend_en;
  logic [NVEC-1:0]   clr_vec;
  logic [CODE_W-1:0] code;
  logic              wr_stat, wr_en, rd_vec;

  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_en   = bus_wr && bus_addr == A_EN;
  assign rd_vec  = bus_rd && bus_addr == A_VEC;
  assign clr_w   = wr_stat ? bus_wdata : '0;
  assign pend_en = stat_q & en_q;
  assign clr_all = clr_w | {{(DW-NVEC){1'b0}}, clr_vec};

  evt_status_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_set (ev_pulse),
    .clr    (clr_all),
    .stat_q (stat_q)
  );

  evt_vec_enc u_vec (
    .pend    (pend_en[NVEC-1:0]),
    .rd_vec  (rd_vec),
    .code    (code),
    .clr_vec (clr_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata & EN_MASK;
  end

  assign irq_o = |pend_en;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_STAT:  bus_rdata = stat_q | (DW'(bus_busy) << BB_BIT);
        A_EN:    bus_rdata = en_q;
        A_VEC:   bus_rdata = DW'(code);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R7: an all-zero mask keeps the line low
  a_r7_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);

  // R6: interrupt and vector agree on whether an event is pending
  a_r6_vec_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> irq_o);

  // R5: enable writes hold unless rewritten
  a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));

  // R9: a vector read with nothing enabled pending leaves status unchanged
  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && code == '0 && !wr_stat && ev_pulse == '0) |=> $stable(stat_q));
endmodule

// File: tb/sim_evt_irq_unit.sv
module sim_evt_irq_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] ev_pulse = '0;
  logic        bus_busy = 0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  evt_irq_unit u0 (.clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .bus_busy(bus_busy),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [15:0] ev);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d; ev_pulse = ev;
    @(negedge clk); bus_wr = 0; ev_pulse = '0;
  endtask

  task automatic pulse(input logic [15:0] ev);
    @(negedge clk); ev_pulse = ev;
    @(negedge clk); ev_pulse = '0;
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d); check(tag, d, exp);
  endtask

  task automatic t_reset;
    chk_reg("R10 status", 2'd0, 16'h0);
    chk_reg("R10 enable", 2'd1, 16'h0);
    chk_reg("R10 vector", 2'd2, 16'h0);
    #1 check("R10 irq", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_sticky_w1c;
    pulse(16'hFFFF);
    chk_reg("R1 sticky all", 2'd0, 16'h6F1F);
    chk_reg("R1 still set", 2'd0, 16'h6F1F);
    wr(2'd0, 16'h0003, 16'h0);
    chk_reg("R2 w1c", 2'd0, 16'h6F1C);
    wr(2'd0, 16'h0000, 16'h0);
    chk_reg("R2 w0 hold", 2'd0, 16'h6F1C);
    wr(2'd0, 16'h6F1C, 16'h0);
    chk_reg("R2 writeback", 2'd0, 16'h0000);
    wr(2'd0, 16'h0008, 16'h0008);
    chk_reg("R3 event wins write", 2'd0, 16'h0008);
    wr(2'd0, 16'hFFFF, 16'h0);
  endtask

  task automatic t_bb_enable;
    bus_busy = 1;
    chk_reg("R4 bb live", 2'd0, 16'h1000);
    wr(2'd0, 16'h1000, 16'h1000);
    chk_reg("R4 bb not cleared", 2'd0, 16'h1000);
    wr(2'd1, 16'hFFFF, 16'h0);
    chk_reg("R5 enable mask", 2'd1, 16'h601F);
    #1 check("R6 bb no irq", {15'b0, irq_o}, 16'h0);
    bus_busy = 0;
    chk_reg("R4 bb low", 2'd0, 16'h0000);
    chk_reg("R11 addr3", 2'd3, 16'h0000);
  endtask

  task automatic t_irq;
    pulse(16'h0100);
    #1 check("R6 non-enabled event", {15'b0, irq_o}, 16'h0);
    pulse(16'h2000);
    #1 check("R6 enabled event", {15'b0, irq_o}, 16'h1);
    wr(2'd1, 16'h0000, 16'h0);
    #1 check("R7 mask zero", {15'b0, irq_o}, 16'h0);
    chk_reg("R7 status kept", 2'd0, 16'h2100);
    wr(2'd0, 16'hFFFF, 16'h0);
  endtask

  task automatic t_vector;
    wr(2'd1, 16'h001F, 16'h0);
    pulse(16'h001A);
    chk_reg("R8 prio nack", 2'd2, 16'd2);
    chk_reg("R9 only reported cleared", 2'd0, 16'h0018);
    chk_reg("R8 next rrdy", 2'd2, 16'd4);
    chk_reg("R8 next xrdy", 2'd2, 16'd5);
    chk_reg("R9 empty vec", 2'd2, 16'd0);
    chk_reg("R9 all acked", 2'd0, 16'h0000);
    wr(2'd1, 16'h001E, 16'h0);
    pulse(16'h0005);
    chk_reg("R8 masked AL skipped", 2'd2, 16'd3);
    chk_reg("R9 AL untouched", 2'd0, 16'h0001);
    wr(2'd1, 16'h001F, 16'h0);
    @(negedge clk); bus_addr = 2'd2; bus_rd = 1; ev_pulse = 16'h0001;
    #1 check("R8 AL first", bus_rdata, 16'd1);
    @(negedge clk); bus_rd = 0; ev_pulse = '0;
    chk_reg("R3 event wins vec read", 2'd0, 16'h0001);
    chk_reg("R9 status read no clear", 2'd0, 16'h0001);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sticky_w1c();
    t_bb_enable();
    t_irq();
    t_vector();
    pulse(16'h0004);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule